// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a parallel flash device. It takes over once the host has issued a program or erase sequence. On a start pulse it reads the flash status word again and again over a simple synchronous bus. Each read goes to the word being programmed, or to any word inside the block being erased. It decides when the internal operation has finished, using one of two methods.

In toggle mode the operation is complete once two reads in a row return the same bit 6. In data-polling mode it is complete once bit 7 shows its final value. For a program, that is bit 7 of the word written. For an erase, it is 1. Bit 5 is the device's error flag. When it is seen set, the poller makes one confirming read and decides between success and failure from that read. After a failure it can send the device's return-to-read command. A programmable limit on the number of reads turns a stalled device into a timeout.

Top module: `flash_done_poller`

## Requirements
- R1: With `use_toggle`=1, `done` is reported when two successive status reads return the same bit 6. The first read alone never completes.
- R2: With `use_toggle`=0, `done` is reported when status bit 7 equals `exp_data[7]` and `is_erase`=0. When `is_erase`=1, `done` is reported when status bit 7 equals 1, and `exp_data` has no effect.
- R3: Every status read is a read (`f_we`=0) to the address given with the start pulse. That address stays fixed for the whole operation.
- R4: If a read that does not complete the operation shows bit 5 = 1, exactly one more read follows. That read reports `done` if it completes the operation by the rule of R1 or R2, and `fail` otherwise.
- R5: On a failure with `auto_reset`=1, exactly one write of `RESET_CMD` (default 16'h00F0) to the operation address happens before `fail` pulses. With `auto_reset`=0, no write happens.
- R6: Status bits 0, 1 and 4 never affect the outcome. Only bits 7, 6 and 5 are examined.
- R7: `timeout` is reported after `max_polls` status reads without completion or error. A `max_polls` of 0 behaves as 1.
- R8: `done`, `fail` and `timeout` are each one-cycle pulses, at most one at a time. `busy` is high from the cycle after an accepted start until the result pulse, and is low during it.
- R9: A `start` asserted while `busy` is high is ignored. The running operation keeps its address and yields one result.
- R10: After reset, `busy`, `done`, `fail`, `timeout`, `f_req` and `f_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| is_erase | input | 1 | 1 = erase in progress, 0 = program |
| use_toggle | input | 1 | 1 = bit-6 toggle method, 0 = bit-7 data polling |
| auto_reset | input | 1 | Issue the return-to-read command after a failure |
| addr | input | AW | Programmed word address or address inside the erased block |
| exp_data | input | DW | Data that was programmed |
| max_polls | input | CW | Read limit before timeout |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| fail | output | 1 | Failure pulse |
| timeout | output | 1 | Timeout pulse |
| f_req | output | 1 | Bus request, held until acknowledged |
| f_we | output | 1 | Bus write enable |
| f_addr | output | AW | Bus address |
| f_wdata | output | DW | Bus write data |
| f_rdata | input | DW | Bus read data, valid with `f_ack` |
| f_ack | input | 1 | Bus acknowledge, one cycle per transfer |

## Verification
Each result pulse appears in the cycle right after the clock edge that samples the acknowledge of the deciding read. For a failure with the reset command enabled, it appears right after the edge that samples the write's acknowledge. It then lasts exactly one cycle, and `busy` is low in that same cycle. The bench model answers the bus on falling edges. Every check samples on the falling edge, so the first falling edge after the deciding acknowledge must show the pulse, and the next one must show it gone. Read and write counts and addresses are logged by the model at the moment each transfer is acknowledged. They are compared once the result is seen.

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter logic [DW-1:0] RESET_CMD = 16'h00F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_erase,
  input  logic          use_toggle,
  input  logic          auto_reset,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] exp_data,
  input  logic [CW-1:0] max_polls,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          timeout,
  output logic          f_req,
  output logic          f_we,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_wdata,
  input  logic [DW-1:0] f_rdata,
  input  logic          f_ack
);
  typedef enum logic [1:0] {S_IDLE, S_POLL, S_CONF, S_RST} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] max_q, cnt;
  logic          tgt7, tog_q, arst_q, prev6, seen;

  wire match   = tog_q ? (seen && f_rdata[6] == prev6) : (f_rdata[7] == tgt7);
  wire last_rd = ({1'b0, cnt} + 1'b1) >= {1'b0, max_q};

  assign busy    = st != S_IDLE;
  assign f_req   = busy;
  assign f_we    = st == S_RST;
  assign f_addr  = addr_q;
  assign f_wdata = RESET_CMD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0; max_q <= '0; cnt <= '0;
      tgt7 <= 1'b0; tog_q <= 1'b0; arst_q <= 1'b0; prev6 <= 1'b0; seen <= 1'b0;
      done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
    end else begin
      done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= addr;
          max_q  <= max_polls;
          tgt7   <= is_erase | exp_data[7];
          tog_q  <= use_toggle;
          arst_q <= auto_reset;
          cnt    <= '0;
          seen   <= 1'b0;
          st     <= S_POLL;
        end
        S_POLL: if (f_ack) begin
          cnt   <= cnt + 1'b1;
          prev6 <= f_rdata[6];
          seen  <= 1'b1;
          if (match) begin
            done <= 1'b1; st <= S_IDLE;
          end else if (f_rdata[5]) begin
            st <= S_CONF;
          end else if (last_rd) begin
            timeout <= 1'b1; st <= S_IDLE;
          end
        end
        S_CONF: if (f_ack) begin
          if (match) begin
            done <= 1'b1; st <= S_IDLE;
          end else if (arst_q) begin
            st <= S_RST;
          end else begin
            fail <= 1'b1; st <= S_IDLE;
          end
        end
        S_RST: if (f_ack) begin
          fail <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_onehot_results_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail, timeout}));
  assert_result_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done | fail | timeout) |-> !busy);
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(f_addr));
  assert_reset_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_we) |-> $past(f_ack));
  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL && max_q != '0) |-> cnt < max_q);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!f_req && !f_we));
endmodule

// File: tb/sim_flash_done_poller.sv
module sim_flash_done_poller;
  localparam int AW = 22, DW = 16, CW = 16;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic start = 0, is_erase = 0, use_toggle = 0, auto_reset = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic [CW-1:0] max_polls = 16'd8;
  logic busy, done, fail, timeout, f_req, f_we, f_ack = 0;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_wdata, f_rdata = '0;

  flash_done_poller u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] seq [16];
  int nrd, nwr, bad_addr;
  logic [DW-1:0] wr_last;
  logic [AW-1:0] exp_addr;

  always @(negedge clk) begin
    if (f_ack) f_ack = 0;
    else if (f_req) begin
      f_ack = 1;
      if (f_addr != exp_addr) bad_addr++;
      if (f_we) begin nwr++; wr_last = f_wdata; end
      else begin f_rdata = seq[(nrd > 15) ? 15 : nrd]; nrd++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, expv); end
  endtask

  // result: 0 none, 1 done, 2 fail, 3 timeout
  task automatic run(input bit er, input bit tg, input bit ar, input logic [DW-1:0] ed,
                     input logic [CW-1:0] mp, input int poke, output int res);
    nrd = 0; nwr = 0; bad_addr = 0; res = 0;
    exp_addr = 22'h1A2B3C ^ AW'(mp);
    @(negedge clk);
    is_erase = er; use_toggle = tg; auto_reset = ar; exp_data = ed;
    max_polls = mp; addr = exp_addr; start = 1;
    @(negedge clk); start = 0;
    chk(busy, "R8 busy after start", busy, 1);
    for (int i = 0; i < 300 && res == 0; i++) begin
      if (i == poke) begin addr = exp_addr ^ 22'h3; start = 1; end
      else start = 0;
      @(negedge clk);
      if (done) res = 1; else if (fail) res = 2; else if (timeout) res = 3;
    end
    start = 0;
    chk(!busy, "R8 busy low with result", busy, 0);
    @(negedge clk);
    chk(!done && !fail && !timeout, "R8 single-cycle pulse", {done, fail, timeout}, 0);
    chk(bad_addr == 0, "R3 bus address", bad_addr, 0);
  endtask

  task automatic t_reset;
    chk({busy, done, fail, timeout, f_req, f_we} == 0, "R10 reset state",
        {busy, done, fail, timeout, f_req, f_we}, 0);
  endtask

  task automatic t_toggle;
    int r;
    seq[0] = 16'h0040; seq[1] = 16'h0000; seq[2] = 16'h0040; seq[3] = 16'h0040;
    run(0, 1, 0, 16'h0, 8, -1, r);
    chk(r == 1, "R1 toggle done", r, 1);
    chk(nrd == 4, "R1 read count", nrd, 4);
  endtask

  task automatic t_data_prog;
    int r;
    seq[0] = 16'h0000; seq[1] = 16'h0040; seq[2] = 16'h0080;
    run(0, 0, 0, 16'h00FF, 8, -1, r);
    chk(r == 1 && nrd == 3, "R2 program bit7=1", nrd, 3);
    seq[0] = 16'h0080; seq[1] = 16'h0000;
    run(0, 0, 0, 16'h0001, 8, -1, r);
    chk(r == 1 && nrd == 2, "R2 program bit7=0", nrd, 2);
  endtask

  task automatic t_data_erase;
    int r;
    seq[0] = 16'h0000; seq[1] = 16'h0040; seq[2] = 16'h0080;
    run(1, 0, 0, 16'h0000, 8, -1, r);
    chk(r == 1 && nrd == 3, "R2 erase waits for 1", nrd, 3);
  endtask

  task automatic t_mask;
    int r;
    seq[0] = 16'h0053; seq[1] = 16'h0040;
    run(0, 1, 0, 16'h0, 8, -1, r);
    chk(r == 1 && nrd == 2, "R6 reserved bits ignored", nrd, 2);
    seq[0] = 16'h0013; seq[1] = 16'h0000; seq[2] = 16'h0093;
    run(0, 0, 0, 16'h0080, 8, -1, r);
    chk(r == 1 && nrd == 3, "R6 reserved bits in data mode", nrd, 3);
  endtask

  task automatic t_err;
    int r;
    seq[0] = 16'h0020; seq[1] = 16'h0020;
    run(0, 0, 1, 16'h0080, 8, -1, r);
    chk(r == 2 && nrd == 2, "R4 confirm read fails", r, 2);
    chk(nwr == 1 && wr_last == 16'h00F0, "R5 reset command written", wr_last, 16'h00F0);
    seq[0] = 16'h0020; seq[1] = 16'h0080;
    run(0, 0, 1, 16'h0080, 8, -1, r);
    chk(r == 1 && nrd == 2 && nwr == 0, "R4 confirm read succeeds", r, 1);
    seq[0] = 16'h0060; seq[1] = 16'h0020; seq[2] = 16'h0000;
    run(0, 1, 0, 16'h0, 8, -1, r);
    chk(r == 2 && nrd == 2, "R4 toggle still running", r, 2);
    chk(nwr == 0, "R5 no write without auto_reset", nwr, 0);
  endtask

  task automatic t_timeout;
    int r;
    for (int i = 0; i < 16; i++) seq[i] = (i % 2) ? 16'h0000 : 16'h0040;
    run(0, 1, 0, 16'h0, 5, -1, r);
    chk(r == 3 && nrd == 5, "R7 timeout after limit", nrd, 5);
    seq[0] = 16'h0000;
    run(0, 0, 0, 16'h0080, 0, -1, r);
    chk(r == 3 && nrd == 1, "R7 zero limit acts as one", nrd, 1);
  endtask

  task automatic t_busy;
    int r;
    for (int i = 0; i < 16; i++) seq[i] = 16'h0000;
    seq[6] = 16'h0080;
    run(0, 0, 0, 16'h0080, 12, 3, r);
    chk(r == 1 && nrd == 7, "R9 start ignored while busy", nrd, 7);
    repeat (4) @(negedge clk);
    chk(!busy && nrd == 7, "R9 no second operation", nrd, 7);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) seq[i] = '0;
    nrd = 0; nwr = 0; bad_addr = 0; exp_addr = '0; wr_last = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_toggle;
    t_data_prog;
    t_data_erase;
    t_mask;
    t_err;
    t_timeout;
    t_busy;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule